// File: doc/BRIEF.md
# Setpoint-Corrected Phase Error Unit

This block sits between two phase-tag sources and a proportional-integral loop filter in a digital clock-recovery loop. One tag source timestamps edges of the reference clock, the other timestamps edges of the locally generated clock. Both tags are counts modulo a tag period of 2^TAG_W. The unit pairs one tag from each source. It subtracts the local tag and the applied phase setpoint from the reference tag, and reduces the result to a signed wrapped error. A cycle counter then extends that wrapped error, so that phase drifts of many clock periods stay continuous rather than folding back. At default sizes the error updates once per tag pair, which is a few kilohertz.

The phase setpoint is requested through a target input. The value the unit actually subtracts does not jump to a new target. It moves one least significant bit per produced error sample until it reaches the target, so the loop filter never sees a step. A synchronous clear empties the pairing state, zeroes the cycle counter, forgets the previous sample and loads the target into the applied setpoint in one go.

Pairing is a three-state machine. `PAIR_EMPTY` holds no pending tag. `PAIR_REF` holds a reference tag that is waiting for a local tag. `PAIR_LOC` holds a local tag that is waiting for a reference tag. The transitions are:
- *capture-ref*: EMPTY to REF.
- *capture-loc*: EMPTY to LOC.
- *pair-same-cycle*: EMPTY to EMPTY when both tags arrive together.
- *complete*: REF to EMPTY or LOC to EMPTY when the missing partner arrives.
- *replace*: REF to REF or LOC to LOC when the same channel delivers again.
- *flush*: any state to EMPTY on clear.

Top module: `phase_err_unit`

## Requirements
- R1: After reset `err_vld` is 0, `err_ext` is 0, `sp_applied` is 0 and no tag is pending.
- R2: The wrapped error of a pair is (reference tag − local tag − `sp_applied`) taken modulo 2^TAG_W and read as two's complement. It lies in [−2^(TAG_W−1), 2^(TAG_W−1)). The setpoint used is the value held before that sample's ramp step.
- R3: `err_vld` pulses high for one cycle, exactly one clock after the cycle in which a pair completes. A pair completes when both channels have a fresh tag, either in the same cycle or across cycles. A single channel on its own never produces an output.
- R4: A tag that arrives on a channel which already holds an unpaired tag replaces the older tag. Only the latest tag is used.
- R5: Let d be the wrapped error minus the previous wrapped error. If d < −2^(TAG_W−1), the signed cycle counter increments. If d > 2^(TAG_W−1), it decrements. The first sample after reset or clear never changes the counter.
- R6: `err_ext` equals the cycle counter × 2^TAG_W plus the sign-extended wrapped error, using the counter value after that sample's update.
- R7: On each produced sample, `sp_applied` moves exactly one LSB toward `sp_target` (signed) and holds once equal. Between samples it does not change.
- R8: `clr` zeroes the cycle counter, discards the previous sample and any pending tags, and loads `sp_target` into `sp_applied` on the next edge. No `err_vld` follows a cycle with `clr` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Synchronous clear of tracking state; loads setpoint |
| ref_vld | input | 1 | Reference tag strobe |
| ref_tag | input | TAG_W | Reference clock phase tag |
| loc_vld | input | 1 | Local tag strobe |
| loc_tag | input | TAG_W | Local clock phase tag |
| sp_target | input | TAG_W | Requested signed phase setpoint |
| sp_applied | output | TAG_W | Signed setpoint currently subtracted |
| err_vld | output | 1 | One-cycle strobe for a new error |
| err_ext | output | CYC_W+TAG_W | Signed extended phase error |

## Verification
The assertions assume that consecutive true phase errors move by less than half a tag period between samples. Under that assumption, one slip per sample is the most the counter can see. They also assume `clr` is held for at most a few cycles and that the cycle counter never runs out of range. The stimulus keeps every step between consecutive pairs below 2^13 counts after setpoint correction, except where a step is chosen on purpose to cross the wrap boundary once. The stimulus also keeps the accumulated counter within ±2.

// File: rtl/phase_err_pkg.sv
package phase_err_pkg;
    typedef enum logic [1:0] {
        PAIR_EMPTY = 2'd0,
        PAIR_REF   = 2'd1,
        PAIR_LOC   = 2'd2
    } pair_state_e;
endpackage

// File: rtl/tag_pairer.sv
module tag_pairer
    import phase_err_pkg::*;
#(
    parameter int TAG_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             ref_vld,
    input  logic [TAG_W-1:0] ref_tag,
    input  logic             loc_vld,
    input  logic [TAG_W-1:0] loc_tag,
    output logic             fire,
    output logic [TAG_W-1:0] ref_out,
    output logic [TAG_W-1:0] loc_out
);
    pair_state_e state, state_nx;
    logic [TAG_W-1:0] ref_hold, loc_hold;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= PAIR_EMPTY;
            ref_hold <= '0;
            loc_hold <= '0;
        end else begin
            state <= state_nx;
            if (ref_vld) ref_hold <= ref_tag;
            if (loc_vld) loc_hold <= loc_tag;
        end
    end

    always_comb begin
        state_nx = state;
        fire     = 1'b0;
        unique case (state)
            PAIR_EMPTY: begin
                if (ref_vld && loc_vld) fire = 1'b1;
                else if (ref_vld)       state_nx = PAIR_REF;
                else if (loc_vld)       state_nx = PAIR_LOC;
            end
            PAIR_REF: begin
                if (loc_vld) begin
                    fire     = 1'b1;
                    state_nx = PAIR_EMPTY;
                end
            end
            PAIR_LOC: begin
                if (ref_vld) begin
                    fire     = 1'b1;
                    state_nx = PAIR_EMPTY;
                end
            end
            default: state_nx = PAIR_EMPTY;
        endcase
        if (clr) begin
            fire     = 1'b0;
            state_nx = PAIR_EMPTY;
        end
    end

    assign ref_out = ref_vld ? ref_tag : ref_hold;
    assign loc_out = loc_vld ? loc_tag : loc_hold;

    AST_FIRE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> state == PAIR_EMPTY); // R3
    AST_LONE_NO_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PAIR_EMPTY && (ref_vld != loc_vld)) |-> !fire); // R3
endmodule

// File: rtl/setpoint_ramp.sv
module setpoint_ramp #(
    parameter int SP_W = 14
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr,
    input  logic                   step,
    input  logic signed [SP_W-1:0] target,
    output logic signed [SP_W-1:0] sp
);
    localparam logic signed [SP_W-1:0] SP_ONE = {{(SP_W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (!rst_n)                     sp <= '0;
        else if (clr)                   sp <= target;
        else if (step && sp != target)  sp <= (sp < target) ? sp + SP_ONE : sp - SP_ONE;
    end

    AST_SP_ONE_LSB: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (sp == $past(sp) || sp == $past(sp) + SP_ONE || sp == $past(sp) - SP_ONE)); // R7
    AST_SP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !step) |=> $stable(sp)); // R7
    AST_SP_CLR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> sp == $past(target)); // R8
endmodule

// File: rtl/slip_tracker.sv
module slip_tracker #(
    parameter int TAG_W = 14,
    parameter int CYC_W = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           clr,
    input  logic                           fire,
    input  logic signed [TAG_W-1:0]        wrapped,
    output logic                           err_vld,
    output logic signed [CYC_W+TAG_W-1:0]  err_ext
);
    localparam int EXT_W  = CYC_W + TAG_W;
    localparam int HALF_I = 1 << (TAG_W - 1);
    localparam logic signed [CYC_W-1:0] CYC_ONE = {{(CYC_W-1){1'b0}}, 1'b1};

    logic signed [TAG_W-1:0] prev_w;
    logic                    have_prev;
    logic signed [CYC_W-1:0] cyc, cyc_nx;
    logic signed [TAG_W:0]   delta;
    logic                    slip_up, slip_dn;
    logic signed [EXT_W-1:0] ext_nx;

    always_comb begin
        delta   = {wrapped[TAG_W-1], wrapped} - {prev_w[TAG_W-1], prev_w};
        slip_up = have_prev && (delta < -HALF_I);
        slip_dn = have_prev && (delta > HALF_I);
        cyc_nx  = cyc;
        if (slip_up)      cyc_nx = cyc + CYC_ONE;
        else if (slip_dn) cyc_nx = cyc - CYC_ONE;
        ext_nx  = {cyc_nx, {TAG_W{1'b0}}} + {{CYC_W{wrapped[TAG_W-1]}}, wrapped};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_w    <= '0;
            have_prev <= 1'b0;
            cyc       <= '0;
            err_vld   <= 1'b0;
            err_ext   <= '0;
        end else if (clr) begin
            have_prev <= 1'b0;
            cyc       <= '0;
            err_vld   <= 1'b0;
        end else begin
            err_vld <= fire;
            if (fire) begin
                prev_w    <= wrapped;
                have_prev <= 1'b1;
                cyc       <= cyc_nx;
                err_ext   <= ext_nx;
            end
        end
    end

    AST_CYC_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (cyc == $past(cyc) || cyc == $past(cyc) + CYC_ONE || cyc == $past(cyc) - CYC_ONE)); // R5
    AST_FIRST_NO_SLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !have_prev && !clr) |=> cyc == $past(cyc)); // R5
    AST_CLR_ZERO_CYC: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cyc == '0 && !have_prev)); // R8
endmodule

// File: rtl/phase_err_unit.sv
module phase_err_unit #(
    parameter int TAG_W = 14,
    parameter int CYC_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clr,
    input  logic                          ref_vld,
    input  logic [TAG_W-1:0]              ref_tag,
    input  logic                          loc_vld,
    input  logic [TAG_W-1:0]              loc_tag,
    input  logic [TAG_W-1:0]              sp_target,
    output logic [TAG_W-1:0]              sp_applied,
    output logic                          err_vld,
    output logic [CYC_W+TAG_W-1:0]        err_ext
);
    localparam int EXT_W = CYC_W + TAG_W;

    logic                    fire;
    logic [TAG_W-1:0]        ref_sel, loc_sel;
    logic signed [TAG_W-1:0] sp_cur;
    logic signed [TAG_W-1:0] wrapped;
    logic signed [EXT_W-1:0] ext_s;

    tag_pairer #(.TAG_W(TAG_W)) u_pair (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .ref_vld(ref_vld), .ref_tag(ref_tag),
        .loc_vld(loc_vld), .loc_tag(loc_tag),
        .fire(fire), .ref_out(ref_sel), .loc_out(loc_sel)
    );

    setpoint_ramp #(.SP_W(TAG_W)) u_ramp (
        .clk(clk), .rst_n(rst_n), .clr(clr), .step(fire),
        .target($signed(sp_target)), .sp(sp_cur)
    );

    assign wrapped = $signed(ref_sel - loc_sel - $unsigned(sp_cur));

    slip_tracker #(.TAG_W(TAG_W), .CYC_W(CYC_W)) u_slip (
        .clk(clk), .rst_n(rst_n), .clr(clr), .fire(fire),
        .wrapped(wrapped), .err_vld(err_vld), .err_ext(ext_s)
    );

    assign err_ext    = $unsigned(ext_s);
    assign sp_applied = $unsigned(sp_cur);

    AST_VLD_AFTER_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        err_vld |-> $past(fire)); // R3
    AST_CLR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !err_vld); // R8
    AST_VLD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (err_vld && !$past(ref_vld && loc_vld)) |=> !err_vld); // R3
endmodule

// File: tb/phase_err_unit_bench.sv
module phase_err_unit_bench;
    localparam int TAG_W = 14;
    localparam int CYC_W = 8;
    localparam int N_VEC = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr = 1'b0;
    logic ref_vld = 1'b0, loc_vld = 1'b0;
    logic [TAG_W-1:0] ref_tag = '0, loc_tag = '0, sp_target = '0;
    logic [TAG_W-1:0] sp_applied;
    logic err_vld;
    logic [CYC_W+TAG_W-1:0] err_ext;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    phase_err_unit #(.TAG_W(TAG_W), .CYC_W(CYC_W)) u_phase_err_unit (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .ref_vld(ref_vld), .ref_tag(ref_tag),
        .loc_vld(loc_vld), .loc_tag(loc_tag),
        .sp_target(sp_target), .sp_applied(sp_applied),
        .err_vld(err_vld), .err_ext(err_ext)
    );

    // ref, loc, expected extended error; setpoint 0, sequence starts after a clear
    localparam int VEC [N_VEC][3] = '{
        '{100,   0,    100},
        '{8000,  0,    8000},
        '{8300,  0,    8300},
        '{16000, 0,    16000},
        '{500,   0,    16884},
        '{0,     8000, 24768},
        '{0,     100,  32668},
        '{100,   8200, 24668},
        '{8200,  100,  24484},
        '{0,     0,    16384}
    };

    function automatic int ext_i();
        return int'($signed(err_ext));
    endfunction
    function automatic int sp_i();
        return int'($signed(sp_applied));
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(input int r, input int l);
        @(negedge clk);
        ref_vld = 1'b1; ref_tag = TAG_W'(r);
        loc_vld = 1'b1; loc_tag = TAG_W'(l);
        @(negedge clk);
        ref_vld = 1'b0; loc_vld = 1'b0;
    endtask

    task automatic one_ref(input int r);
        @(negedge clk); ref_vld = 1'b1; ref_tag = TAG_W'(r);
        @(negedge clk); ref_vld = 1'b0;
    endtask

    task automatic one_loc(input int l);
        @(negedge clk); loc_vld = 1'b1; loc_tag = TAG_W'(l);
        @(negedge clk); loc_vld = 1'b0;
    endtask

    task automatic do_clear(input int tgt);
        @(negedge clk); sp_target = TAG_W'(tgt); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 vld", int'(err_vld), 0);
        chk("R1 ext", ext_i(), 0);
        chk("R1 sp", sp_i(), 0);
        rst_n = 1'b1;

        // table walk: wrap, slips up and down, extension
        do_clear(0);
        chk("R8 no vld after clear", int'(err_vld), 0);
        for (int i = 0; i < N_VEC; i++) begin
            send(VEC[i][0], VEC[i][1]);
            chk("R3 vld", int'(err_vld), 1);
            chk("R2/R5/R6 ext", ext_i(), VEC[i][2]);
        end
        @(negedge clk);
        chk("R3 one-cycle pulse", int'(err_vld), 0);

        // pairing across cycles and tag replacement
        do_clear(0);
        one_ref(10);
        chk("R3 lone ref", int'(err_vld), 0);
        one_ref(20);
        chk("R4 repeated ref", int'(err_vld), 0);
        one_loc(5);
        chk("R3 pair complete", int'(err_vld), 1);
        chk("R4 latest ref used", ext_i(), 15);
        one_loc(7);
        one_loc(0);
        chk("R4 repeated loc", int'(err_vld), 0);
        one_ref(30);
        chk("R4 latest loc used", ext_i(), 30);

        // setpoint ramp up then down
        do_clear(0);
        @(negedge clk); sp_target = TAG_W'(3);
        repeat (3) @(negedge clk);
        chk("R7 no move without sample", sp_i(), 0);
        begin
            int exp_e[10] = '{0, -1, -2, -3, -3, -3, -2, -1, 0, 1};
            int exp_s[10] = '{1, 2, 3, 3, 3, 2, 1, 0, -1, -1};
            for (int k = 0; k < 10; k++) begin
                if (k == 5) begin
                    @(negedge clk); sp_target = TAG_W'(-1);
                end
                send(1000, 1000);
                chk("R2 setpoint-corrected ext", ext_i(), exp_e[k]);
                chk("R7 sp step", sp_i(), exp_s[k]);
            end
        end

        // clear loads target and zeroes counter; negative slip
        send(0, 9000);
        do_clear(50);
        chk("R8 sp loaded", sp_i(), 50);
        send(0, 8000);
        chk("R8 first after clear", ext_i(), -8050);
        send(0, 8400);
        chk("R5 downward slip", ext_i(), -8450);

        // clear discards a pending tag
        @(negedge clk); clr = 1'b1; ref_vld = 1'b1; ref_tag = TAG_W'(77);
        @(negedge clk); clr = 1'b0; ref_vld = 1'b0;
        one_loc(0);
        chk("R8 pending flushed", int'(err_vld), 0);
        one_ref(60);
        chk("R8 pair after flush", ext_i(), 10);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule